// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps receive-path calibration results for several radio chains so that they can be put back into the radio without running the calibration again. Each chain owns a small table of six 28-bit entries: three DC offset DAC values (loop, low and high), a filter calibration word, the receive gain settings and the peak detector offset. Software reaches the entries indirectly, through a command register and a data register per chain. It writes a command with the access bit at 0 to set the direction and entry address, then writes it again with the access bit at 1. The block performs the transfer after a fixed latency and clears the access bit, which software polls.

A single control register holds a retention enable, a per-entry restore mask and a force-restore bit. Setting the force-restore bit replays the stored table onto a parallel radio bus, one slot per cycle, chain by chain in ascending order. Entries whose mask bit is set are skipped silently. Hardware clears the bit when the replay is over. While retention is disabled, any pending access or restore request is dropped within one cycle, so a polling loop always ends.

Top module: `cal_retain_ctrl`

## Requirements
- R1: After reset every register reads 0, every table entry reads back as 0 and `rad_valid` is 0.
- R2: The control register at address 0 holds the enable in bit 0 and the restore mask in bits 6:1, where bit 1+i masks entry i. Bit 7 is the force-restore bit. Enable and mask read back as written.
- R3: Chain c has its command register at address 2c+1 and its data register at address 2c+2. In the command register, bit 0 is the access bit, bit 1 is write (1) or read (0), and bits 4:2 are the entry address. The data register carries the entry in bits 31:4, and bits 3:0 read 0.
- R4: A command write with bit 0 at 1, made while the access bit reads 0, starts an access. The access bit then reads 1 for exactly 4 cycles after the write edge and reads 0 after that. While it reads 1, writes to that chain's command and data registers are ignored.
- R5: A write access stores data bits 31:4 into the addressed entry. A read access loads the addressed entry into the data register by the time the access bit clears. Writing 0 to every entry leaves the table reading all zeros.
- R6: Entry addresses 6 and 7 complete with normal timing. A write to them changes no entry, and a read from them leaves the data register unchanged.
- R7: An access to one chain changes neither the table nor the data register of any other chain.
- R8: While the enable is 0, an access or force-restore request is dropped: its bit reads 0 one cycle after the write edge, no entry changes and `rad_valid` stays 0.
- R9: With the enable at 1, writing bit 7 as 1 starts a replay. In the k-th cycle after the write edge (k = 0..17), the bus shows chain k/6 and entry k%6 with that entry's data. `rad_valid` is 1 exactly when the mask bit of that entry is 0. Bit 7 reads 1 for those 18 cycles and reads 0 after them.
- R10: A control write made during a replay neither cancels it (bit 7 written 0) nor restarts it (bit 7 written 1). The slot sequence and the end cycle stay as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data, combinational from `reg_raddr` |
| rad_valid | output | 1 | Radio bus slot carries an unmasked entry |
| rad_chain | output | 2 | Chain index of the current slot |
| rad_entry | output | 3 | Entry index of the current slot |
| rad_data | output | 28 | Entry value of the current slot |

## Verification
The bench builds the block with its default parameters: three chains, six entries of 28 bits and an access latency of 4. Three chains make the chain order of the replay and the independence between chains observable. Because the address field is 3 bits wide for six entries, addresses 6 and 7 can be issued and checked as no-ops. A latency of 4 leaves room to write into a busy chain and to observe the exact cycle in which the access bit clears.

// File: rtl/cal_retain_pkg.sv
package cal_retain_pkg;

  localparam int REG_W = 32;

  // Register index of chain c's command register
  function automatic int cmd_reg(input int c);
    return 2 * c + 1;
  endfunction

  // Register index of chain c's data register
  function automatic int data_reg(input int c);
    return 2 * c + 2;
  endfunction

  // Control word: enable at bit 0, mask from bit 1, force just above the mask
  function automatic logic [REG_W-1:0] pack_ctrl(input logic en, input logic [15:0] mask,
                                                 input logic frc, input int n_ent);
    logic [REG_W-1:0] v;
    v = {31'd0, en};
    v = v | ({16'd0, mask} << 1);
    v = v | ({31'd0, frc} << (n_ent + 1));
    return v;
  endfunction

  // Command word: access bit 0, write bit 1, address from bit 2
  function automatic logic [REG_W-1:0] pack_cmd(input logic acc, input logic wr,
                                                input logic [7:0] addr);
    return {22'd0, addr, wr, acc};
  endfunction

endpackage

// File: rtl/cal_chain_port.sv
module cal_chain_port #(
  parameter int NUM_ENTRIES = 6,
  parameter int ENTRY_W     = 28,
  parameter int ACC_LAT     = 4,
  localparam int EW  = $clog2(NUM_ENTRIES),
  localparam int CW  = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1,
  localparam int LSB = 32 - ENTRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cmd_we,
  input  logic               data_we,
  input  logic [31:0]        wdata,
  output logic [31:0]        cmd_rd,
  output logic [31:0]        data_rd,
  output logic               acc_busy,
  output logic               acc_done,
  input  logic [EW-1:0]      rs_entry,
  output logic [ENTRY_W-1:0] rs_data
);

  logic               acc_q;
  logic               wr_q;
  logic [EW-1:0]      addr_q;
  logic [CW-1:0]      cnt_q;
  logic [ENTRY_W-1:0] data_q;
  logic [ENTRY_W-1:0] tab_q [NUM_ENTRIES];
  logic               start;
  logic               addr_ok;
  logic [ENTRY_W-1:0] sel_q;

  assign start    = cmd_we && wdata[0] && !acc_q;
  assign acc_done = acc_q && en && (cnt_q == CW'(ACC_LAT - 1));
  assign acc_busy = acc_q;
  assign addr_ok  = (int'(addr_q) < NUM_ENTRIES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      acc_q  <= 1'b1;
      wr_q   <= wdata[1];
      addr_q <= wdata[EW+1:2];
      cnt_q  <= '0;
    end else if (cmd_we && !acc_q) begin
      wr_q   <= wdata[1];
      addr_q <= wdata[EW+1:2];
    end else if (acc_q) begin
      if (!en || acc_done) acc_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  // Table entries, one register each
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab_q[e] <= '0;
      else if (acc_done && wr_q && addr_q == EW'(e)) tab_q[e] <= data_q;
    end
  end

  always_comb begin
    sel_q   = '0;
    rs_data = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (addr_q == EW'(e))   sel_q   = tab_q[e];
      if (rs_entry == EW'(e)) rs_data = tab_q[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (data_we && !acc_q) data_q <= wdata[31:LSB];
    else if (acc_done && !wr_q && addr_ok) data_q <= sel_q;
  end

  assign cmd_rd  = {{(32-EW-2){1'b0}}, addr_q, wr_q, acc_q};
  assign data_rd = {data_q, {LSB{1'b0}}};

endmodule

// File: rtl/cal_restore_seq.sv
module cal_restore_seq #(
  parameter int NUM_CHAINS  = 3,
  parameter int NUM_ENTRIES = 6,
  localparam int CHW = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
  localparam int EW  = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   start,
  input  logic [NUM_ENTRIES-1:0] mask,
  output logic                   busy,
  output logic                   slot_valid,
  output logic [CHW-1:0]         slot_chain,
  output logic [EW-1:0]          slot_entry
);

  logic           busy_q;
  logic [CHW-1:0] ch_q;
  logic [EW-1:0]  ent_q;
  logic           last_ent;
  logic           last_slot;

  assign last_ent  = (ent_q == EW'(NUM_ENTRIES - 1));
  assign last_slot = last_ent && (ch_q == CHW'(NUM_CHAINS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= '0;
      ent_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        ch_q   <= '0;
        ent_q  <= '0;
      end
    end else if (!en || last_slot) begin
      busy_q <= 1'b0;
    end else if (last_ent) begin
      ent_q <= '0;
      ch_q  <= ch_q + 1'b1;
    end else begin
      ent_q <= ent_q + 1'b1;
    end
  end

  assign busy       = busy_q;
  assign slot_chain = ch_q;
  assign slot_entry = ent_q;
  assign slot_valid = busy_q && en && !mask[ent_q];

endmodule

// File: rtl/cal_retain_ctrl.sv
module cal_retain_ctrl #(
  parameter int NUM_CHAINS  = 3,
  parameter int NUM_ENTRIES = 6,
  parameter int ENTRY_W     = 28,
  parameter int ACC_LAT     = 4,
  parameter int REG_AW      = 4,
  localparam int CHW = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
  localparam int EW  = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_waddr,
  input  logic [31:0]        reg_wdata,
  input  logic [REG_AW-1:0]  reg_raddr,
  output logic [31:0]        reg_rdata,
  output logic               rad_valid,
  output logic [CHW-1:0]     rad_chain,
  output logic [EW-1:0]      rad_entry,
  output logic [ENTRY_W-1:0] rad_data
);
  import cal_retain_pkg::*;

  logic                   en_q;
  logic [NUM_ENTRIES-1:0] mask_q;
  logic                   ctrl_we;
  logic                   rst_busy;
  logic [31:0]            ctrl_rd;
  logic [NUM_CHAINS-1:0]  acc_busy;
  logic [NUM_CHAINS-1:0]  acc_done;
  logic [31:0]            cmd_rd  [NUM_CHAINS];
  logic [31:0]            data_rd [NUM_CHAINS];
  logic [ENTRY_W-1:0]     rs_data [NUM_CHAINS];

  assign ctrl_we = reg_we && (reg_waddr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (ctrl_we) begin
      en_q   <= reg_wdata[0];
      mask_q <= reg_wdata[NUM_ENTRIES:1];
    end
  end

  cal_restore_seq #(
    .NUM_CHAINS (NUM_CHAINS),
    .NUM_ENTRIES(NUM_ENTRIES)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .start     (ctrl_we && reg_wdata[NUM_ENTRIES+1]),
    .mask      (mask_q),
    .busy      (rst_busy),
    .slot_valid(rad_valid),
    .slot_chain(rad_chain),
    .slot_entry(rad_entry)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    cal_chain_port #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .ENTRY_W    (ENTRY_W),
      .ACC_LAT    (ACC_LAT)
    ) i_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .cmd_we  (reg_we && int'(reg_waddr) == cmd_reg(c)),
      .data_we (reg_we && int'(reg_waddr) == data_reg(c)),
      .wdata   (reg_wdata),
      .cmd_rd  (cmd_rd[c]),
      .data_rd (data_rd[c]),
      .acc_busy(acc_busy[c]),
      .acc_done(acc_done[c]),
      .rs_entry(rad_entry),
      .rs_data (rs_data[c])
    );
  end

  assign ctrl_rd = pack_ctrl(en_q, 16'(mask_q), rst_busy, NUM_ENTRIES);

  always_comb begin
    reg_rdata = '0;
    rad_data  = '0;
    if (reg_raddr == '0) reg_rdata = ctrl_rd;
    for (int c = 0; c < NUM_CHAINS; c++) begin
      if (int'(reg_raddr) == cmd_reg(c))  reg_rdata = cmd_rd[c];
      if (int'(reg_raddr) == data_reg(c)) reg_rdata = data_rd[c];
      if (rad_chain == CHW'(c))           rad_data  = rs_data[c];
    end
  end

endmodule

// File: rtl/cal_retain_chk.sv
module cal_retain_chk #(
  parameter int NUM_CHAINS  = 3,
  parameter int NUM_ENTRIES = 6,
  localparam int EW = $clog2(NUM_ENTRIES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic                  rst_busy,
  input logic                  rad_valid,
  input logic [EW-1:0]         rad_entry,
  input logic [NUM_CHAINS-1:0] acc_busy,
  input logic [NUM_CHAINS-1:0] acc_done
);

  // R8: a restore request is dropped within one cycle while disabled
  assert_restore_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy && !en |=> !rst_busy);

  // R9: radio strobe only during an enabled replay, on a real entry
  assert_valid_in_replay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rad_valid |-> rst_busy && en && (int'(rad_entry) < NUM_ENTRIES));

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_c
    // R8: an access is dropped within one cycle while disabled
    assert_access_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_busy[c] && !en |=> !acc_busy[c]);

    // R4: completion clears the access bit
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done[c] |=> !acc_busy[c]);

    // R4: a fresh access lasts more than one cycle when enabled
    assert_access_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_busy[c]) && en |=> acc_busy[c]);
  end

endmodule

bind cal_retain_ctrl cal_retain_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .NUM_ENTRIES(NUM_ENTRIES)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en_q),
  .rst_busy (rst_busy),
  .rad_valid(rad_valid),
  .rad_entry(rad_entry),
  .acc_busy (acc_busy),
  .acc_done (acc_done)
);

// File: tb/test_cal_retain_ctrl.sv
module test_cal_retain_ctrl;

  localparam int NC  = 3;
  localparam int NE  = 6;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        rad_valid;
  logic [1:0]  rad_chain;
  logic [2:0]  rad_entry;
  logic [27:0] rad_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cal_retain_ctrl i_cal_retain_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .rad_valid(rad_valid), .rad_chain(rad_chain), .rad_entry(rad_entry),
    .rad_data(rad_data)
  );

  // Address map and word layouts, restated from the requirements
  function automatic logic [3:0] a_cmd(input int c);  return 4'(2*c + 1); endfunction
  function automatic logic [3:0] a_dat(input int c);  return 4'(2*c + 2); endfunction
  function automatic logic [31:0] w_cmd(input logic acc, input logic wr, input int e);
    return (32'(e) << 2) | (32'(wr) << 1) | 32'(acc);
  endfunction
  function automatic logic [31:0] w_ctrl(input logic en, input logic [5:0] m, input logic f);
    return (32'(f) << 7) | (32'(m) << 1) | 32'(en);
  endfunction
  function automatic logic [27:0] pat(input int c, input int e);
    return 28'h5A0_0000 + 28'(c * 256 + e * 17);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic access(input int c, input logic w, input int e);
    wr(a_cmd(c), w_cmd(1'b0, w, e));
    wr(a_cmd(c), w_cmd(1'b1, w, e));
    repeat (LAT) @(negedge clk);
  endtask

  task automatic put(input int c, input int e, input logic [27:0] v);
    wr(a_dat(c), {v, 4'h0});
    access(c, 1'b1, e);
  endtask

  task automatic get(input int c, input int e, output logic [27:0] v);
    logic [31:0] d;
    access(c, 1'b0, e);
    rd(a_dat(c), d);
    v = d[31:4];
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic ok;
    logic [27:0] v;
    ok = 1'b1;
    for (int a = 0; a <= 2*NC; a++) begin
      rd(4'(a), d);
      if (d != 0) ok = 1'b0;
    end
    check(ok, "R1 registers zero after reset", {31'd0, ok}, 32'd1);
    check(rad_valid == 1'b0, "R1 rad_valid low after reset", 32'(rad_valid), 32'd0);
    wr(4'd0, w_ctrl(1'b1, 6'd0, 1'b0));
    get(2, 5, v);
    check(v == 0, "R1 table entry zero after reset", 32'(v), 32'd0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(4'd0, w_ctrl(1'b1, 6'b101101, 1'b0));
    rd(4'd0, d);
    check(d == 32'h0000_005B, "R2 control enable and mask readback", d, 32'h5B);
    wr(a_cmd(1), w_cmd(1'b0, 1'b1, 5));
    rd(a_cmd(1), d);
    check(d == 32'h0000_0016, "R3 command fields readback", d, 32'h16);
    wr(a_dat(1), 32'hABCD_123F);
    rd(a_dat(1), d);
    check(d == 32'hABCD_1230, "R3 data bits 31:4 kept, 3:0 zero", d, 32'hABCD_1230);
    wr(4'd0, w_ctrl(1'b1, 6'd0, 1'b0));
  endtask

  task automatic t_latency;
    logic [31:0] d;
    logic [27:0] v;
    wr(a_dat(0), {28'h1234567, 4'h0});
    wr(a_cmd(0), w_cmd(1'b0, 1'b1, 2));
    wr(a_cmd(0), w_cmd(1'b1, 1'b1, 2));     // cycle 0
    rd(a_cmd(0), d);
    check(d[0] == 1'b1, "R4 access bit set at cycle 0", d, 32'h1);
    wr(a_dat(0), {28'h7654321, 4'h0});      // cycle 1, must be ignored
    wr(a_cmd(0), w_cmd(1'b0, 1'b0, 4));     // cycle 2, must be ignored
    rd(a_cmd(0), d);
    check(d == w_cmd(1'b1, 1'b1, 2), "R4 command frozen while busy", d, w_cmd(1'b1, 1'b1, 2));
    @(negedge clk);                          // cycle 3
    rd(a_cmd(0), d);
    check(d[0] == 1'b1, "R4 access bit set at cycle 3", d, 32'h1);
    @(negedge clk);                          // cycle 4
    rd(a_cmd(0), d);
    check(d[0] == 1'b0, "R4 access bit clear at cycle 4", d, 32'h0);
    get(0, 2, v);
    check(v == 28'h1234567, "R4 data write during busy ignored / R5 stored", 32'(v), 32'h1234567);
  endtask

  task automatic t_rw;
    logic [27:0] v;
    logic ok;
    for (int e = 0; e < NE; e++) put(1, e, pat(1, e));
    ok = 1'b1;
    for (int e = NE - 1; e >= 0; e--) begin
      get(1, e, v);
      if (v != pat(1, e)) ok = 1'b0;
    end
    check(ok, "R5 write then read all entries of chain 1", {31'd0, ok}, 32'd1);
    put(2, 3, 28'hFEDCBA9);
    get(1, 3, v);
    check(v == pat(1, 3), "R7 chain 2 write leaves chain 1", 32'(v), 32'(pat(1, 3)));
    get(0, 3, v);
    check(v == 28'h0, "R7 chain 2 write leaves chain 0", 32'(v), 32'h0);
  endtask

  task automatic t_bad_addr;
    logic [31:0] d;
    logic [27:0] v;
    logic ok;
    put(1, 7, 28'h0BADBAD);
    put(1, 6, 28'h0BADBAD);
    ok = 1'b1;
    for (int e = 0; e < NE; e++) begin
      get(1, e, v);
      if (v != pat(1, e)) ok = 1'b0;
    end
    check(ok, "R6 write to address 6/7 changes no entry", {31'd0, ok}, 32'd1);
    wr(a_dat(1), {28'h0C0FFEE, 4'h0});
    access(1, 1'b0, 6);
    rd(a_dat(1), d);
    check(d[31:4] == 28'h0C0FFEE, "R6 read of address 6 leaves data", d, {28'h0C0FFEE, 4'h0});
    rd(a_cmd(1), d);
    check(d[0] == 1'b0, "R6 address 6 access completes", d, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    logic [27:0] v;
    wr(4'd0, w_ctrl(1'b0, 6'd0, 1'b0));
    wr(a_dat(0), {28'h1111111, 4'h0});
    wr(a_cmd(0), w_cmd(1'b0, 1'b1, 1));
    wr(a_cmd(0), w_cmd(1'b1, 1'b1, 1));
    @(negedge clk);
    rd(a_cmd(0), d);
    check(d[0] == 1'b0, "R8 access dropped within one cycle", d, 32'h0);
    wr(4'd0, w_ctrl(1'b0, 6'd0, 1'b1));
    check(rad_valid == 1'b0, "R8 no radio strobe when disabled", 32'(rad_valid), 32'h0);
    @(negedge clk);
    rd(4'd0, d);
    check(d[7] == 1'b0, "R8 force bit dropped within one cycle", d, 32'h0);
    wr(4'd0, w_ctrl(1'b1, 6'd0, 1'b0));
    get(0, 1, v);
    check(v == 28'h0, "R8 entry unchanged by dropped write", 32'(v), 32'h0);
  endtask

  task automatic load_all;
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) put(c, e, pat(c, e));
  endtask

  task automatic check_slot(input int k, input logic [5:0] m, inout logic ok);
    logic [31:0] d;
    int c, e;
    c = k / NE;
    e = k % NE;
    rd(4'd0, d);
    if (d[7] != 1'b1 || rad_chain != 2'(c) || rad_entry != 3'(e) || rad_valid != !m[e])
      ok = 1'b0;
    if (!m[e] && rad_data != pat(c, e)) ok = 1'b0;
  endtask

  task automatic t_restore;
    logic [31:0] d;
    logic ok;
    logic [5:0] m;
    m = 6'b010010;
    load_all();
    wr(4'd0, w_ctrl(1'b1, m, 1'b1));
    ok = 1'b1;
    for (int k = 0; k < NC * NE; k++) begin
      check_slot(k, m, ok);
      @(negedge clk);
    end
    check(ok, "R9 replay slots, order, mask and data", {31'd0, ok}, 32'd1);
    rd(4'd0, d);
    check(d[7] == 1'b0, "R9 force bit clears after 18 cycles", d, 32'h0);
    check(rad_valid == 1'b0, "R9 no strobe after replay", 32'(rad_valid), 32'h0);
  endtask

  task automatic t_overlap;
    logic [31:0] d;
    logic ok;
    logic [5:0] m;
    m = 6'b100001;
    wr(4'd0, w_ctrl(1'b1, m, 1'b1));
    repeat (5) @(negedge clk);
    wr(4'd0, w_ctrl(1'b1, m, 1'b0));   // now at slot 6
    wr(4'd0, w_ctrl(1'b1, m, 1'b1));   // now at slot 7
    ok = 1'b1;
    for (int k = 7; k < NC * NE; k++) begin
      check_slot(k, m, ok);
      @(negedge clk);
    end
    check(ok, "R10 replay not cancelled or restarted", {31'd0, ok}, 32'd1);
    rd(4'd0, d);
    check(d[7] == 1'b0, "R10 force bit clears on schedule", d, 32'h0);
  endtask

  task automatic t_clear;
    logic [27:0] v;
    logic ok;
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) put(c, e, 28'h0);
    ok = 1'b1;
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) begin
        get(c, e, v);
        if (v != 0) ok = 1'b0;
      end
    check(ok, "R5 zero writes clear the table", {31'd0, ok}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_latency();
    t_rw();
    t_bad_addr();
    t_disabled();
    t_restore();
    t_overlap();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule